// File: doc/BRIEF.md
# Register Write-Pending Scoreboard

This block keeps one pending-write bit for each architectural register. Issue logic uses it to find read-after-write hazards. When an execution unit is issued an instruction that writes a register, the bit for that destination is raised. The bit drops again in either of two cases:

- the result is written back through one of the writeback ports;
- the unit finishes without marking its result valid, so the write will never come.

Operand checks made at issue time compare the source registers against the current bits. The results from all check ports are merged into one conflict flag. That flag, together with an input saying whether a free unit was found, forms the busy indication used when instructions may overlap.

Register addresses can be binary indices or one-hot masks; a parameter chooses which. Units flagged as memory units never take the no-result clear path. Their destination is always assumed to be written back.

Top module: `regwr_scoreboard`

## Requirements
- R1: After reset every pending bit is 0, so no check port reports a hazard.
- R2: The bit of `u_dest[u]` is set on a clock edge only when `u_issue[u]`, `u_sel[u]` and `u_wrflag[u]` are all 1 in that cycle.
- R3: A cycle with `wb_en[p]` = 1 clears the bit addressed by `wb_addr[p]` at the next edge.
- R4: Each unit latches `u_wrflag` and `u_dest` on a cycle with `u_issue` and `u_sel` both 1. The latched write flag returns to 0 after any other cycle in which `u_busy` is 0.
- R5: A cycle with `u_done` = 1, `u_res_ok` = 0 and the unit's latched write flag at 1 clears the bit of the latched destination. With `u_res_ok` = 1 the bit stays set.
- R6: A unit whose bit in `MEM_UNITS` is 1 never clears a bit through the R5 path.
- R7: `rc_hazard[r]` is 1 exactly when `rc_issue[r]` and `rc_rdflag[r]` are 1 and the bit addressed by `rc_addr[r]` is set.
- R8: Checks see only the registered state: a set requested in the same cycle is not visible until after the next edge.
- R9: `conflict` is the OR of all `rc_hazard` bits, and `issue_busy` = !`unit_found` | `conflict`.
- R10: Set and clear requests from all ports combine as masks in one cycle. Several bits may be set together, and where a set and a clear hit the same bit, the bit ends up set.
- R11: With `ENC` = ENC_BINARY, address value k selects register k. With `ENC` = ENC_ONEHOT, an address is a mask with bit k selecting register k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| u_issue | input | NUNITS | Per-unit issue strobe |
| u_sel | input | NUNITS | Per-unit selected-by-picker flag |
| u_wrflag | input | NUNITS | Instruction writes a register |
| u_dest | input | NUNITS x AW | Destination register address per unit |
| u_busy | input | NUNITS | Unit is occupied |
| u_done | input | NUNITS | Unit finished its operation |
| u_res_ok | input | NUNITS | Unit's result is valid and will be written |
| wb_en | input | NWB | Writeback port enable |
| wb_addr | input | NWB x AW | Writeback register address |
| rc_issue | input | NRD | Issue strobe of the unit owning the check port |
| rc_rdflag | input | NRD | Operand is actually read |
| rc_addr | input | NRD x AW | Source register address to check |
| rc_hazard | output | NRD | Pending write found for that source |
| unit_found | input | 1 | A free unit was picked for the instruction |
| conflict | output | 1 | Any check port reports a hazard |
| issue_busy | output | 1 | Issue must hold: no unit found or a conflict |

## Verification
The assertions take it for granted that every address is in range. In one-hot mode they also assume an enabled address carries at most one set bit. The bench drives only register numbers below NREGS and single-bit masks, and it returns every address to zero when idle. The latch assertions assume `u_done` arrives while `u_busy` is still high. Every completion scenario in the bench holds busy through the done cycle, except the one that deliberately lets the unit go idle first.

// File: rtl/pend_pkg.sv
package pend_pkg;

   typedef enum logic {
      ENC_BINARY = 1'b0,
      ENC_ONEHOT = 1'b1
   } addr_enc_e;

   function automatic int unsigned addr_w(int unsigned nregs, addr_enc_e enc);
      if (enc == ENC_ONEHOT) return nregs;
      return (nregs < 2) ? 1 : $clog2(nregs);
   endfunction

endpackage

// File: rtl/pend_addr_decode.sv
module pend_addr_decode #(
   parameter int unsigned         NREGS = 32,
   parameter pend_pkg::addr_enc_e ENC   = pend_pkg::ENC_BINARY,
   localparam int unsigned        AW    = pend_pkg::addr_w(NREGS, ENC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [AW-1:0]    addr,
   output logic [NREGS-1:0] mask
);

   generate
      if (ENC == pend_pkg::ENC_ONEHOT) begin : g_onehot
         assign mask = en ? addr : '0;

         // R11: a one-hot address names at most one register
         assert_onehot_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
            en |-> $onehot0(addr));
      end else begin : g_binary
         always_comb begin
            for (int i = 0; i < NREGS; i++) begin
               mask[i] = en && (addr == AW'(i));
            end
         end

         // R11: a binary address stays inside the register range
         assert_addr_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
            en |-> (mask != '0));
      end
   endgenerate

endmodule

// File: rtl/pend_unit_track.sv
module pend_unit_track #(
   parameter int unsigned         NREGS  = 32,
   parameter pend_pkg::addr_enc_e ENC    = pend_pkg::ENC_BINARY,
   parameter bit                  IS_MEM = 1'b0,
   localparam int unsigned        AW     = pend_pkg::addr_w(NREGS, ENC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic             sel,
   input  logic             wrflag,
   input  logic [AW-1:0]    dest,
   input  logic             busy,
   input  logic             done,
   input  logic             res_ok,
   output logic [NREGS-1:0] set_m,
   output logic [NREGS-1:0] clr_m
);

   logic          take;
   logic          latch_wf;
   logic [AW-1:0] latch_dest;
   logic          set_en;
   logic          clr_en;

   assign take   = issue && sel;
   assign set_en = take && wrflag;
   // memory units always write back, so they never use the no-result clear
   assign clr_en = (IS_MEM == 1'b0) && done && latch_wf && !res_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_wf   <= 1'b0;
         latch_dest <= '0;
      end else begin
         if (!busy) latch_wf <= 1'b0;
         if (take) begin
            latch_wf   <= wrflag;
            latch_dest <= dest;
         end
      end
   end

   pend_addr_decode #(.NREGS(NREGS), .ENC(ENC)) u_set_dec (
      .clk(clk), .rst_n(rst_n), .en(set_en), .addr(dest), .mask(set_m)
   );

   pend_addr_decode #(.NREGS(NREGS), .ENC(ENC)) u_clr_dec (
      .clk(clk), .rst_n(rst_n), .en(clr_en), .addr(latch_dest), .mask(clr_m)
   );

   // R4: an idle unit with no issue forgets its write flag
   assert_latch_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !take) |=> !latch_wf);

   // R4: an issue captures the instruction's write flag
   assert_latch_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (latch_wf == $past(wrflag)));

   // R2: a set request only accompanies a selected, writing issue
   assert_set_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_m != '0) |-> (issue && sel && wrflag));

   // R5: a no-result clear only follows a completion without valid data
   assert_noresult_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_m != '0) |-> (done && !res_ok));

endmodule

// File: rtl/pend_bits.sv
module pend_bits #(
   parameter int unsigned NREGS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NREGS-1:0] set_m,
   input  logic [NREGS-1:0] clr_m,
   output logic [NREGS-1:0] bits
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits <= '0;
      else        bits <= (bits & ~clr_m) | set_m;
   end

   // R2: every requested set is visible after the edge
   assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_m != '0) |=> ((bits & $past(set_m)) == $past(set_m)));

   // R3: a clear without a competing set empties the bit
   assert_clear_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_m & ~set_m) != '0) |=> ((bits & $past(clr_m & ~set_m)) == '0));

   // R10: where set and clear collide the bit ends set
   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_m & clr_m) != '0) |=> ((bits & $past(set_m & clr_m)) == $past(set_m & clr_m)));

   // R10: bits no port touched keep their value
   assert_untouched_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((bits ^ $past(bits)) & ~$past(set_m | clr_m)) == '0));

endmodule

// File: rtl/pend_read_check.sv
module pend_read_check #(
   parameter int unsigned         NREGS = 32,
   parameter pend_pkg::addr_enc_e ENC   = pend_pkg::ENC_BINARY,
   localparam int unsigned        AW    = pend_pkg::addr_w(NREGS, ENC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NREGS-1:0] bits,
   input  logic             issue,
   input  logic             rdflag,
   input  logic [AW-1:0]    addr,
   output logic             hazard
);

   logic [NREGS-1:0] chk_m;

   pend_addr_decode #(.NREGS(NREGS), .ENC(ENC)) u_dec (
      .clk(clk), .rst_n(rst_n), .en(issue && rdflag), .addr(addr), .mask(chk_m)
   );

   assign hazard = |(bits & chk_m);

   // R7: a hazard needs an enabled check and some pending register
   assert_hazard_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hazard |-> (issue && rdflag && (bits != '0)));

endmodule

// File: rtl/regwr_scoreboard.sv
module regwr_scoreboard #(
   parameter int unsigned           NREGS     = 32,
   parameter int unsigned           NUNITS    = 4,
   parameter int unsigned           NWB       = 2,
   parameter int unsigned           NRD       = 3,
   parameter pend_pkg::addr_enc_e   ENC       = pend_pkg::ENC_BINARY,
   parameter logic [NUNITS-1:0]     MEM_UNITS = '0,
   localparam int unsigned          AW        = pend_pkg::addr_w(NREGS, ENC)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUNITS-1:0]          u_issue,
   input  logic [NUNITS-1:0]          u_sel,
   input  logic [NUNITS-1:0]          u_wrflag,
   input  logic [NUNITS-1:0][AW-1:0]  u_dest,
   input  logic [NUNITS-1:0]          u_busy,
   input  logic [NUNITS-1:0]          u_done,
   input  logic [NUNITS-1:0]          u_res_ok,
   input  logic [NWB-1:0]             wb_en,
   input  logic [NWB-1:0][AW-1:0]     wb_addr,
   input  logic [NRD-1:0]             rc_issue,
   input  logic [NRD-1:0]             rc_rdflag,
   input  logic [NRD-1:0][AW-1:0]     rc_addr,
   output logic [NRD-1:0]             rc_hazard,
   input  logic                       unit_found,
   output logic                       conflict,
   output logic                       issue_busy
);

   generate
      if (NREGS < 2) begin : g_bad_nregs
         $error("regwr_scoreboard: NREGS must be at least 2");
      end
      if (NUNITS < 1) begin : g_bad_nunits
         $error("regwr_scoreboard: NUNITS must be at least 1");
      end
      if (NWB < 1) begin : g_bad_nwb
         $error("regwr_scoreboard: NWB must be at least 1");
      end
      if (NRD < 1) begin : g_bad_nrd
         $error("regwr_scoreboard: NRD must be at least 1");
      end
   endgenerate

   logic [NUNITS-1:0][NREGS-1:0] unit_set_m;
   logic [NUNITS-1:0][NREGS-1:0] unit_clr_m;
   logic [NWB-1:0][NREGS-1:0]    wb_clr_m;
   logic [NREGS-1:0]             set_all;
   logic [NREGS-1:0]             clr_all;
   logic [NREGS-1:0]             pend;

   for (genvar u = 0; u < NUNITS; u++) begin : g_unit
      pend_unit_track #(.NREGS(NREGS), .ENC(ENC), .IS_MEM(MEM_UNITS[u])) u_track (
         .clk(clk), .rst_n(rst_n),
         .issue(u_issue[u]), .sel(u_sel[u]), .wrflag(u_wrflag[u]),
         .dest(u_dest[u]), .busy(u_busy[u]), .done(u_done[u]),
         .res_ok(u_res_ok[u]),
         .set_m(unit_set_m[u]), .clr_m(unit_clr_m[u])
      );
   end

   for (genvar p = 0; p < NWB; p++) begin : g_wb
      pend_addr_decode #(.NREGS(NREGS), .ENC(ENC)) u_wb_dec (
         .clk(clk), .rst_n(rst_n), .en(wb_en[p]), .addr(wb_addr[p]),
         .mask(wb_clr_m[p])
      );
   end

   always_comb begin
      set_all = '0;
      clr_all = '0;
      for (int u = 0; u < NUNITS; u++) begin
         set_all = set_all | unit_set_m[u];
         clr_all = clr_all | unit_clr_m[u];
      end
      for (int p = 0; p < NWB; p++) begin
         clr_all = clr_all | wb_clr_m[p];
      end
   end

   pend_bits #(.NREGS(NREGS)) u_bits (
      .clk(clk), .rst_n(rst_n), .set_m(set_all), .clr_m(clr_all), .bits(pend)
   );

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      pend_read_check #(.NREGS(NREGS), .ENC(ENC)) u_chk (
         .clk(clk), .rst_n(rst_n), .bits(pend),
         .issue(rc_issue[r]), .rdflag(rc_rdflag[r]), .addr(rc_addr[r]),
         .hazard(rc_hazard[r])
      );
   end

   assign conflict   = |rc_hazard;
   assign issue_busy = !unit_found || conflict;

   // R9: a detected conflict always holds issue
   assert_conflict_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      conflict |-> issue_busy);

   // R9: with no unit available issue is held
   assert_nounit_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !unit_found |-> issue_busy);

endmodule

// File: tb/regwr_scoreboard_test.sv
module regwr_scoreboard_test;

   localparam int NR  = 32;
   localparam int NU  = 4;
   localparam int NW  = 2;
   localparam int NRD = 3;
   localparam int AW  = 5;
   localparam int OHR = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NU-1:0]          u_issue, u_sel, u_wrflag, u_busy, u_done, u_res_ok;
   logic [NU-1:0][AW-1:0]  u_dest;
   logic [NW-1:0]          wb_en;
   logic [NW-1:0][AW-1:0]  wb_addr;
   logic [NRD-1:0]         rc_issue, rc_rdflag, rc_hazard;
   logic [NRD-1:0][AW-1:0] rc_addr;
   logic                   unit_found, conflict, issue_busy;

   regwr_scoreboard #(.NREGS(NR), .NUNITS(NU), .NWB(NW), .NRD(NRD),
                      .ENC(pend_pkg::ENC_BINARY), .MEM_UNITS(4'b1000)) uut (
      .clk(clk), .rst_n(rst_n),
      .u_issue(u_issue), .u_sel(u_sel), .u_wrflag(u_wrflag), .u_dest(u_dest),
      .u_busy(u_busy), .u_done(u_done), .u_res_ok(u_res_ok),
      .wb_en(wb_en), .wb_addr(wb_addr),
      .rc_issue(rc_issue), .rc_rdflag(rc_rdflag), .rc_addr(rc_addr),
      .rc_hazard(rc_hazard), .unit_found(unit_found),
      .conflict(conflict), .issue_busy(issue_busy)
   );

   logic [0:0]           oh_issue, oh_sel, oh_wrflag, oh_busy, oh_done, oh_res_ok;
   logic [0:0][OHR-1:0]  oh_dest;
   logic [0:0]           oh_wb_en;
   logic [0:0][OHR-1:0]  oh_wb_addr;
   logic [0:0]           oh_rc_issue, oh_rc_rdflag, oh_rc_hazard;
   logic [0:0][OHR-1:0]  oh_rc_addr;
   logic                 oh_conflict, oh_busy_out;

   regwr_scoreboard #(.NREGS(OHR), .NUNITS(1), .NWB(1), .NRD(1),
                      .ENC(pend_pkg::ENC_ONEHOT), .MEM_UNITS(1'b0)) uut_oh (
      .clk(clk), .rst_n(rst_n),
      .u_issue(oh_issue), .u_sel(oh_sel), .u_wrflag(oh_wrflag), .u_dest(oh_dest),
      .u_busy(oh_busy), .u_done(oh_done), .u_res_ok(oh_res_ok),
      .wb_en(oh_wb_en), .wb_addr(oh_wb_addr),
      .rc_issue(oh_rc_issue), .rc_rdflag(oh_rc_rdflag), .rc_addr(oh_rc_addr),
      .rc_hazard(oh_rc_hazard), .unit_found(1'b1),
      .conflict(oh_conflict), .issue_busy(oh_busy_out)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   task automatic chk(input logic act, input logic exp, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", what, act, exp);
      end
   endtask

   task automatic quiet();
      u_issue = '0; u_sel = '0; u_wrflag = '0; u_dest = '0;
      u_busy = '0; u_done = '0; u_res_ok = '0;
      wb_en = '0; wb_addr = '0;
      rc_issue = '0; rc_rdflag = '0; rc_addr = '0;
      unit_found = 1'b1;
      oh_issue = '0; oh_sel = '0; oh_wrflag = '0; oh_dest = '0;
      oh_busy = '0; oh_done = '0; oh_res_ok = '0;
      oh_wb_en = '0; oh_wb_addr = '0;
      oh_rc_issue = '0; oh_rc_rdflag = '0; oh_rc_addr = '0;
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic probe(input int r, input logic exp, input string what);
      rc_issue[0] = 1'b1; rc_rdflag[0] = 1'b1; rc_addr[0] = AW'(r);
      #1;
      chk(rc_hazard[0], exp, what);
      rc_issue[0] = 1'b0; rc_rdflag[0] = 1'b0; rc_addr[0] = '0;
   endtask

   task automatic issue_unit(input int u, input int r, input logic sel, input logic wf,
                             input logic busy);
      u_issue[u] = 1'b1; u_sel[u] = sel; u_wrflag[u] = wf;
      u_dest[u] = AW'(r); u_busy[u] = busy;
   endtask

   task automatic t_reset();
      probe(0,  1'b0, "R1 reg0 clear after reset");
      probe(5,  1'b0, "R1 reg5 clear after reset");
      probe(31, 1'b0, "R1 reg31 clear after reset");
   endtask

   task automatic t_set_gate();
      issue_unit(0, 5, 1'b1, 1'b1, 1'b0);
      issue_unit(1, 6, 1'b0, 1'b1, 1'b0);
      issue_unit(2, 7, 1'b1, 1'b0, 1'b0);
      tick(); quiet();
      probe(5, 1'b1, "R2 selected writing issue sets");
      probe(6, 1'b0, "R2 unselected unit does not set");
      probe(7, 1'b0, "R2 write flag low does not set");
   endtask

   task automatic t_writeback();
      wb_en[0] = 1'b1; wb_addr[0] = AW'(5);
      tick(); quiet();
      probe(5, 1'b0, "R3 writeback clears");
      issue_unit(0, 13, 1'b1, 1'b1, 1'b0);
      issue_unit(1, 14, 1'b1, 1'b1, 1'b0);
      tick(); quiet();
      probe(13, 1'b1, "R10 two units set reg13");
      probe(14, 1'b1, "R10 two units set reg14");
      wb_en = 2'b11; wb_addr[0] = AW'(13); wb_addr[1] = AW'(14);
      tick(); quiet();
      probe(13, 1'b0, "R10 two writebacks clear reg13");
      probe(14, 1'b0, "R10 two writebacks clear reg14");
   endtask

   task automatic t_noresult();
      issue_unit(1, 9, 1'b1, 1'b1, 1'b1);
      tick(); quiet();
      u_busy[1] = 1'b1; u_done[1] = 1'b1; u_res_ok[1] = 1'b0;
      tick(); quiet();
      probe(9, 1'b0, "R5 completion without result clears");
      issue_unit(1, 10, 1'b1, 1'b1, 1'b1);
      tick(); quiet();
      u_busy[1] = 1'b1; u_done[1] = 1'b1; u_res_ok[1] = 1'b1;
      tick(); quiet();
      probe(10, 1'b1, "R5 completion with result keeps bit");
      wb_en[0] = 1'b1; wb_addr[0] = AW'(10);
      tick(); quiet();
   endtask

   task automatic t_latch_drop();
      issue_unit(2, 11, 1'b1, 1'b1, 1'b1);
      tick(); quiet();
      tick();
      u_busy[2] = 1'b1; u_done[2] = 1'b1; u_res_ok[2] = 1'b0;
      tick(); quiet();
      probe(11, 1'b1, "R4 idle cycle drops latched write flag");
      wb_en[0] = 1'b1; wb_addr[0] = AW'(11);
      tick(); quiet();
   endtask

   task automatic t_mem_unit();
      issue_unit(3, 12, 1'b1, 1'b1, 1'b1);
      tick(); quiet();
      u_busy[3] = 1'b1; u_done[3] = 1'b1; u_res_ok[3] = 1'b0;
      tick(); quiet();
      probe(12, 1'b1, "R6 memory unit never clears on no result");
      wb_en[1] = 1'b1; wb_addr[1] = AW'(12);
      tick(); quiet();
      probe(12, 1'b0, "R6 memory unit dest cleared by writeback");
   endtask

   task automatic t_read_gate();
      issue_unit(0, 20, 1'b1, 1'b1, 1'b0);
      #1;
      probe(20, 1'b0, "R8 same-cycle set not visible");
      tick(); quiet();
      probe(20, 1'b1, "R8 set visible after edge");
      rc_issue[0] = 1'b1; rc_rdflag[0] = 1'b0; rc_addr[0] = AW'(20);
      #1; chk(rc_hazard[0], 1'b0, "R7 read flag low gives no hazard");
      rc_issue[0] = 1'b0; rc_rdflag[0] = 1'b1;
      #1; chk(rc_hazard[0], 1'b0, "R7 issue low gives no hazard");
      quiet();
   endtask

   task automatic t_conflict();
      unit_found = 1'b1;
      rc_issue[1] = 1'b1; rc_rdflag[1] = 1'b1; rc_addr[1] = AW'(0);
      #1;
      chk(conflict, 1'b0, "R9 no pending source gives no conflict");
      chk(issue_busy, 1'b0, "R9 found unit and no conflict is not busy");
      unit_found = 1'b0;
      #1; chk(issue_busy, 1'b1, "R9 no unit found is busy");
      unit_found = 1'b1;
      rc_issue[2] = 1'b1; rc_rdflag[2] = 1'b1; rc_addr[2] = AW'(20);
      #1;
      chk(rc_hazard[2], 1'b1, "R7 port 2 sees pending reg20");
      chk(conflict, 1'b1, "R9 hazard on port 2 raises conflict");
      chk(issue_busy, 1'b1, "R9 conflict makes busy");
      quiet();
   endtask

   task automatic t_set_wins();
      issue_unit(0, 21, 1'b1, 1'b1, 1'b0);
      wb_en[0] = 1'b1; wb_addr[0] = AW'(21);
      tick(); quiet();
      probe(21, 1'b1, "R10 set beats clear on same bit");
   endtask

   task automatic t_onehot();
      oh_issue[0] = 1'b1; oh_sel[0] = 1'b1; oh_wrflag[0] = 1'b1; oh_dest[0] = 8'h04;
      tick(); quiet();
      oh_rc_issue[0] = 1'b1; oh_rc_rdflag[0] = 1'b1; oh_rc_addr[0] = 8'h04;
      #1; chk(oh_rc_hazard[0], 1'b1, "R11 one-hot mask 0x04 pending");
      oh_rc_addr[0] = 8'h08;
      #1; chk(oh_rc_hazard[0], 1'b0, "R11 one-hot mask 0x08 not pending");
      quiet();
      oh_wb_en[0] = 1'b1; oh_wb_addr[0] = 8'h04;
      tick(); quiet();
      oh_rc_issue[0] = 1'b1; oh_rc_rdflag[0] = 1'b1; oh_rc_addr[0] = 8'h04;
      #1; chk(oh_rc_hazard[0], 1'b0, "R11 one-hot writeback clears");
      quiet();
   endtask

   initial begin
      quiet();
      repeat (3) @(posedge clk);
      #2;
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_set_gate();
      t_writeback();
      t_noresult();
      t_latch_drop();
      t_mem_unit();
      t_read_gate();
      t_conflict();
      t_set_wins();
      t_onehot();
      tick();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule